// File: doc/BRIEF.md
# Word FIFO DMA Request Bridge

This block moves 16-bit words from a host bus into a DMA channel that belongs to a second processor. The host programs a transfer length, sets an enable bit in a control register, and then writes data words one at a time into a small FIFO. Each transfer to the channel side is a burst whose size is a multiple of four words. When the FIFO holds a non-zero multiple of four words and the channel is armed and globally enabled, the bridge drains the buffered words. Each word goes out as a write to the channel's destination address, and that address advances by two bytes per word.

The channel's destination address, transfer count, two-bit control field and master enable live inside the bridge and are loaded through a separate configuration port. Completion is tracked in two places. The host length register counts down, and the host enable bit drops once the length reaches zero. The channel count also counts down, and the channel's end flag is raised once the count reaches zero. The destination side is a single word-write port with a valid/ready handshake.

Top module: `drq_bridge`

## Requirements
- R1: A host write to register index 1 (length) stores the written value with bits [1:0] forced to zero, so that index 1 reads back a multiple of four.
- R2: A host write to register index 2 (FIFO data) has no effect while the enable bit (control register bit 2) is 0.
- R3: Accepted FIFO writes are kept in arrival order. FULL (control register bit 7) is set once DEPTH words are held, and further FIFO writes are dropped while FULL is set.
- R4: A drain begins only when the held word count is a non-zero multiple of four, the channel control field bits [1:0] equal 01, and the master enable (channel register 3, bit 0) is 1.
- R5: Each drained word appears on the destination port at the current destination address. The address then advances by 2, the channel count drops by one, and the host length drops by one, never going below zero.
- R6: When a drain ends, the FIFO is emptied and FULL is cleared. The enable bit is cleared if and only if the length has reached zero, and the next drain continues from the advanced address.
- R7: When the channel count reaches zero, the drain stops and any words still held are discarded. Channel control bit 1 (end flag) is set, which also blocks further drains until the field is rewritten.
- R8: A host write to register index 0 (control) takes only bit 2 (enable) and bit 0 (rv) from the data. The current FULL bit is kept whatever the data holds.
- R9: While the destination ready input is low, the destination valid output, address and data hold steady.
- R10: Reset clears the FIFO level, FULL, the length, the enable bit, the rv bit and all channel registers, and drives no destination write.
- R11: While a drain is starting or in progress, host FIFO writes and channel configuration writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register index: 0 control, 1 length, 2 FIFO data, 3 unused |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for host_addr (control: bit7 FULL, bit2 enable, bit0 rv; index 2 and 3 read 0) |
| ch_we | input | 1 | Channel configuration write strobe |
| ch_sel | input | 2 | Channel register: 0 destination address, 1 count, 2 control field, 3 master enable |
| ch_wdata | input | ADDR_W | Channel configuration data |
| ch_count | output | CNT_W | Remaining channel transfer count |
| ch_ctl | output | 2 | Channel control field: bit1 end flag, bit0 armed |
| dst_valid | output | 1 | Destination write valid |
| dst_ready | input | 1 | Destination write ready |
| dst_addr | output | ADDR_W | Destination byte address |
| dst_data | output | DATA_W | Destination write data |

## Verification
A FIFO level that does not match the words actually accepted shows up at the destination port during the next drain, as a burst that is too long or too short or that carries stale data. A dropped or extra pointer reset makes a burst start early, late or never. A wrong length or channel count shows up as a wrong read-back value or a wrong end flag in the cycle after the drain's final handshake. A stalled transfer that lets the address or data slip shows up at once, as a destination write that moves while ready is low.

// File: rtl/drq_pkg.sv
package drq_pkg;

    typedef enum logic [1:0] {
        HREG_CTRL = 2'd0,
        HREG_LEN  = 2'd1,
        HREG_FIFO = 2'd2,
        HREG_NONE = 2'd3
    } host_reg_e;

    typedef enum logic [1:0] {
        CREG_DST = 2'd0,
        CREG_CNT = 2'd1,
        CREG_CTL = 2'd2,
        CREG_MEN = 2'd3
    } chan_reg_e;

    localparam int CTL_RV_BIT   = 0;
    localparam int CTL_EN_BIT   = 2;
    localparam int CTL_FULL_BIT = 7;

    // channel control field: bit1 end flag, bit0 armed
    typedef struct packed {
        logic ended;
        logic armed;
    } chan_ctl_t;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_MOVE = 1'b1
    } drain_state_e;

    function automatic logic burst_ready(input int unsigned lvl);
        return (lvl != 0) && (lvl[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/drq_word_fifo.sv
module drq_word_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              flush,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && level == LVL_W'(g)) begin
                store[g] <= push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            full  <= 1'b0;
        end else if (flush) begin
            level <= '0;
            full  <= 1'b0;
        end else if (push) begin
            level <= level + LVL_W'(1);
            full  <= (level + LVL_W'(1)) == LVL_W'(DEPTH);
        end
    end

    assign rd_data = store[rd_idx];

endmodule

// File: rtl/drq_host_regs.sv
module drq_host_regs #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              len_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              len_dec,
    input  logic              drain_end,
    output logic              xfer_en,
    output logic              rv,
    output logic [LEN_W-1:0]  len
);
    import drq_pkg::*;

    logic [LEN_W-1:0] len_nxt;

    always_comb begin
        len_nxt = len;
        if (len_we) begin
            len_nxt = wdata[LEN_W-1:0] & ~LEN_W'(3);
        end else if (len_dec && len != '0) begin
            len_nxt = len - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len     <= '0;
            xfer_en <= 1'b0;
            rv      <= 1'b0;
        end else begin
            len <= len_nxt;
            if (ctrl_we) begin
                xfer_en <= wdata[CTL_EN_BIT];
                rv      <= wdata[CTL_RV_BIT];
            end
            if (drain_end && len_nxt == '0) begin
                xfer_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/drq_chan_engine.sv
module drq_chan_engine #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int LVL_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [LVL_W-1:0]  level,
    input  logic              dst_ready,
    output logic              dst_valid,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy,
    output logic              word_step,
    output logic              drain_end,
    output logic [CNT_W-1:0]  count,
    output logic [1:0]        ctl,
    output logic              men
);
    import drq_pkg::*;

    drain_state_e      state;
    chan_ctl_t         ctl_q;
    logic              men_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] dst_q;
    logic [IDX_W-1:0]  idx_q;
    logic              gate, start, last;

    assign gate      = ctl_q.armed && !ctl_q.ended && men_q && burst_ready(32'(level));
    assign start     = (state == DR_IDLE) && gate;
    assign word_step = (state == DR_MOVE) && dst_ready;
    assign last      = word_step &&
                       (((LVL_W'(idx_q) + LVL_W'(1)) == level) || (cnt_q == CNT_W'(1)));
    assign drain_end = last || (start && cnt_q == '0);
    assign busy      = start || (state == DR_MOVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DR_IDLE;
            ctl_q <= '0;
            men_q <= 1'b0;
            cnt_q <= '0;
            dst_q <= '0;
            idx_q <= '0;
        end else begin
            case (state)
                DR_IDLE: begin
                    if (start) begin
                        if (cnt_q == '0) begin
                            ctl_q.ended <= 1'b1;
                        end else begin
                            state <= DR_MOVE;
                            idx_q <= '0;
                        end
                    end else if (cfg_we) begin
                        case (cfg_sel)
                            CREG_DST: dst_q <= cfg_wdata;
                            CREG_CNT: cnt_q <= cfg_wdata[CNT_W-1:0];
                            CREG_CTL: ctl_q <= cfg_wdata[1:0];
                            default:  men_q <= cfg_wdata[0];
                        endcase
                    end
                end
                default: begin
                    if (word_step) begin
                        dst_q <= dst_q + ADDR_W'(2);
                        cnt_q <= cnt_q - CNT_W'(1);
                        idx_q <= idx_q + IDX_W'(1);
                        if (last) begin
                            state <= DR_IDLE;
                            idx_q <= '0;
                            if (cnt_q == CNT_W'(1)) begin
                                ctl_q.ended <= 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign dst_valid = (state == DR_MOVE);
    assign dst_addr  = dst_q;
    assign rd_idx    = idx_q;
    assign count     = cnt_q;
    assign ctl       = ctl_q;
    assign men       = men_q;

endmodule

// File: rtl/drq_bridge.sv
module drq_bridge #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ch_we,
    input  logic [1:0]        ch_sel,
    input  logic [ADDR_W-1:0] ch_wdata,
    output logic [CNT_W-1:0]  ch_count,
    output logic [1:0]        ch_ctl,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [DATA_W-1:0] dst_data
);
    import drq_pkg::*;

    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic             ctrl_we, len_we, fifo_we, push;
    logic             xfer_en, rv_q, fifo_full, busy, word_step, drain_end, chan_men;
    logic [LEN_W-1:0] len_q;
    logic [LVL_W-1:0] fifo_level;
    logic [IDX_W-1:0] rd_idx;

    assign ctrl_we = host_we && (host_addr == HREG_CTRL);
    assign len_we  = host_we && (host_addr == HREG_LEN);
    assign fifo_we = host_we && (host_addr == HREG_FIFO);
    assign push    = fifo_we && xfer_en && !fifo_full && !busy;

    drq_host_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .len_we    (len_we),
        .wdata     (host_wdata),
        .len_dec   (word_step),
        .drain_end (drain_end),
        .xfer_en   (xfer_en),
        .rv        (rv_q),
        .len       (len_q)
    );

    drq_word_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (host_wdata),
        .flush     (drain_end),
        .rd_idx    (rd_idx),
        .level     (fifo_level),
        .full      (fifo_full),
        .rd_data   (dst_data)
    );

    drq_chan_engine #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W), .IDX_W(IDX_W)
    ) u_chan (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (ch_we),
        .cfg_sel   (ch_sel),
        .cfg_wdata (ch_wdata),
        .level     (fifo_level),
        .dst_ready (dst_ready),
        .dst_valid (dst_valid),
        .dst_addr  (dst_addr),
        .rd_idx    (rd_idx),
        .busy      (busy),
        .word_step (word_step),
        .drain_end (drain_end),
        .count     (ch_count),
        .ctl       (ch_ctl),
        .men       (chan_men)
    );

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            HREG_CTRL: begin
                host_rdata[CTL_FULL_BIT] = fifo_full;
                host_rdata[CTL_EN_BIT]   = xfer_en;
                host_rdata[CTL_RV_BIT]   = rv_q;
            end
            HREG_LEN: host_rdata[LEN_W-1:0] = len_q;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/drq_bridge_chk.sv
module drq_bridge_chk #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [1:0]        host_addr,
    input logic [LEN_W-1:0]  len,
    input logic              xfer_en,
    input logic              full,
    input logic [LVL_W-1:0]  level,
    input logic              ch_we,
    input logic [1:0]        ch_sel,
    input logic [1:0]        ch_ctl,
    input logic              men,
    input logic [CNT_W-1:0]  ch_count,
    input logic              dst_valid,
    input logic              dst_ready,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [DATA_W-1:0] dst_data
);

    AST_LEN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd1) |=> (len[1:0] == 2'b00)); // R1

    AST_NO_PUSH_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !xfer_en |=> (level <= $past(level))); // R2

    AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (rst)
        full |-> (level == LVL_W'(DEPTH))); // R3

    AST_DRAIN_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(dst_valid) |-> $past(ch_ctl == 2'b01 && men && level != '0 && level[1:0] == 2'b00)); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && dst_ready) |=> (dst_addr == $past(dst_addr) + ADDR_W'(2))); // R5

    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        $fell(dst_valid) |-> (!full && level == '0)); // R6

    AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!ch_ctl[1] && !(ch_we && ch_sel == 2'd2)) |=> (!ch_ctl[1] || ch_count == '0)); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_addr) && $stable(dst_data))); // R9

endmodule

bind drq_bridge drq_bridge_chk #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_addr (host_addr),
    .len       (len_q),
    .xfer_en   (xfer_en),
    .full      (fifo_full),
    .level     (fifo_level),
    .ch_we     (ch_we),
    .ch_sel    (ch_sel),
    .ch_ctl    (ch_ctl),
    .men       (chan_men),
    .ch_count  (ch_count),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_addr  (dst_addr),
    .dst_data  (dst_data)
);

// File: tb/drq_bridge_test.sv
`timescale 1ns/1ps
module drq_bridge_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ch_we = 1'b0;
    logic [1:0]  ch_sel = 2'd0;
    logic [31:0] ch_wdata = '0;
    logic [23:0] ch_count;
    logic [1:0]  ch_ctl;
    logic        dst_valid;
    logic        dst_ready = 1'b0;
    logic [31:0] dst_addr;
    logic [15:0] dst_data;

    int nchk = 0;
    int nerr = 0;
    int ncap = 0;
    logic [31:0] cap_addr [64];
    logic [15:0] cap_data [64];

    always #2.5 clk = ~clk;

    drq_bridge uut (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ch_we(ch_we), .ch_sel(ch_sel), .ch_wdata(ch_wdata),
        .ch_count(ch_count), .ch_ctl(ch_ctl),
        .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_addr(dst_addr), .dst_data(dst_data)
    );

    // record every accepted destination write
    always @(negedge clk) begin
        if (!rst && dst_valid && dst_ready) begin
            cap_addr[ncap[5:0]] = dst_addr;
            cap_data[ncap[5:0]] = dst_data;
            ncap = ncap + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        tick(1);
        host_we = 1'b0;
    endtask

    task automatic cwrite(input logic [1:0] s, input logic [31:0] d);
        ch_we = 1'b1; ch_sel = s; ch_wdata = d;
        tick(1);
        ch_we = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    typedef struct packed {
        logic [15:0] len;
        logic [3:0]  nw;
        logic [1:0]  mode;
        logic        men;
        logic [15:0] cnt;
        logic [3:0]  xw;
        logic [15:0] xlen;
        logic        xen;
        logic        xend;
        logic [15:0] xcnt;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{16'd8,  4'd4, 2'b01, 1'b1, 16'd16, 4'd4, 16'd4,  1'b1, 1'b0, 16'd12},
        '{16'd4,  4'd4, 2'b01, 1'b1, 16'd4,  4'd4, 16'd0,  1'b0, 1'b1, 16'd0},
        '{16'd7,  4'd4, 2'b01, 1'b1, 16'd2,  4'd2, 16'd2,  1'b1, 1'b1, 16'd0},
        '{16'd16, 4'd3, 2'b01, 1'b1, 16'd8,  4'd0, 16'd16, 1'b1, 1'b0, 16'd8},
        '{16'd16, 4'd4, 2'b11, 1'b1, 16'd8,  4'd0, 16'd16, 1'b1, 1'b1, 16'd8},
        '{16'd16, 4'd4, 2'b01, 1'b0, 16'd8,  4'd0, 16'd16, 1'b1, 1'b0, 16'd8}
    };

    initial begin
        #250000;
        nerr++;
        $display("Watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int base;
        row_t t;

        // R10: reset state
        do_reset();
        hread(2'd0, rd); check("R10 ctrl after reset", rd, 16'h0000);
        hread(2'd1, rd); check("R10 len after reset", rd, 16'h0000);
        check("R10 dst_valid after reset", dst_valid, 1'b0);
        check("R10 count after reset", ch_count, 0);
        check("R10 ctl after reset", ch_ctl, 2'b00);

        // table walk: R1 R4 R5 R6 R7
        for (int r = 0; r < 6; r++) begin
            t = ROWS[r];
            do_reset();
            dst_ready = 1'b1;
            hwrite(2'd0, 16'h0004);
            hwrite(2'd1, t.len);
            hread(2'd1, rd); check("R1 length aligned", rd, t.len & 16'hFFFC);
            cwrite(2'd0, 32'h0600_0000 + 32'(r) * 32'h100);
            cwrite(2'd1, 32'(t.cnt));
            cwrite(2'd3, 32'(t.men));
            cwrite(2'd2, 32'(t.mode));
            base = ncap;
            for (int i = 0; i < int'(t.nw); i++) hwrite(2'd2, 16'hA000 + 16'(r * 16 + i));
            tick(12);
            check("R4 drained word count", ncap - base, 32'(t.xw));
            for (int i = 0; i < int'(t.xw); i++) begin
                check("R5 dst address", cap_addr[6'(base + i)], 32'h0600_0000 + 32'(r) * 32'h100 + 32'(2 * i));
                check("R5 dst data", cap_data[6'(base + i)], 16'hA000 + 16'(r * 16 + i));
            end
            hread(2'd1, rd); check("R5 length after drain", rd, t.xlen);
            hread(2'd0, rd); check("R6 enable after drain", rd[2], t.xen);
            check("R5 channel count", ch_count, 32'(t.xcnt));
            check("R7 end flag", ch_ctl[1], t.xend);
        end

        // R2: FIFO writes ignored while enable is clear
        do_reset();
        dst_ready = 1'b1;
        hwrite(2'd1, 16'd16);
        cwrite(2'd0, 32'h1000); cwrite(2'd1, 32'd8); cwrite(2'd3, 32'd1); cwrite(2'd2, 32'd1);
        base = ncap;
        for (int i = 0; i < 4; i++) hwrite(2'd2, 16'hD000 + 16'(i));
        tick(8);
        check("R2 no drain while disabled", ncap - base, 0);
        hread(2'd0, rd); check("R2 ctrl unchanged", rd, 16'h0000);
        hwrite(2'd0, 16'h0004);
        for (int i = 0; i < 4; i++) hwrite(2'd2, 16'hE000 + 16'(i));
        tick(10);
        check("R2 drain after enable", ncap - base, 4);
        check("R2 first address", cap_addr[6'(base)], 32'h1000);
        for (int i = 0; i < 4; i++) check("R2 only new words", cap_data[6'(base + i)], 16'hE000 + 16'(i));

        // R3 and R8: fill to FULL, control write keeps FULL
        do_reset();
        dst_ready = 1'b1;
        hwrite(2'd0, 16'h0004);
        hwrite(2'd1, 16'd16);
        for (int i = 0; i < 10; i++) hwrite(2'd2, 16'hC000 + 16'(i));
        hread(2'd0, rd); check("R3 FULL set at depth", rd, 16'h0084);
        hwrite(2'd0, 16'h0001);
        hread(2'd0, rd); check("R8 FULL kept, en/rv taken", rd, 16'h0081);
        hwrite(2'd0, 16'h00FE);
        hread(2'd0, rd); check("R8 only en and rv bits", rd, 16'h0084);
        base = ncap;
        cwrite(2'd0, 32'h2000); cwrite(2'd1, 32'd16); cwrite(2'd3, 32'd1); cwrite(2'd2, 32'd1);
        tick(14);
        check("R3 drained depth words", ncap - base, 8);
        for (int i = 0; i < 8; i++) check("R3 order kept, extras dropped", cap_data[6'(base + i)], 16'hC000 + 16'(i));
        hread(2'd0, rd); check("R6 FULL cleared, enable kept", rd, 16'h0004);
        hread(2'd1, rd); check("R5 length decremented", rd, 16'd8);

        // R9 and R11: stall, writes during drain
        do_reset();
        dst_ready = 1'b0;
        hwrite(2'd0, 16'h0004);
        hwrite(2'd1, 16'd32);
        cwrite(2'd0, 32'h3000); cwrite(2'd1, 32'd20); cwrite(2'd3, 32'd1); cwrite(2'd2, 32'd1);
        base = ncap;
        for (int i = 0; i < 4; i++) hwrite(2'd2, 16'hF000 + 16'(i));
        tick(3);
        check("R9 valid while stalled", dst_valid, 1'b1);
        check("R9 address held", dst_addr, 32'h3000);
        check("R9 data held", dst_data, 16'hF000);
        hwrite(2'd2, 16'hFFFF);
        cwrite(2'd1, 32'd5);
        tick(2);
        check("R9 address still held", dst_addr, 32'h3000);
        check("R11 channel write dropped", ch_count, 20);
        dst_ready = 1'b1;
        tick(10);
        check("R11 FIFO write dropped", ncap - base, 4);
        for (int i = 0; i < 4; i++) check("R9 stalled data order", cap_data[6'(base + i)], 16'hF000 + 16'(i));
        check("R5 count after burst", ch_count, 16);
        hread(2'd1, rd); check("R5 length after burst", rd, 16'd28);
        base = ncap;
        for (int i = 0; i < 4; i++) hwrite(2'd2, 16'h7000 + 16'(i));
        tick(10);
        check("R6 next burst after empty", ncap - base, 4);
        check("R6 address continues", cap_addr[6'(base)], 32'h3008);
        check("R6 next burst data", cap_data[6'(base)], 16'h7000);

        summary();
        $finish;
    end

endmodule